// File: doc/BRIEF.md
# Network Board Control and Parity Capture Register

This block is the host-facing control and status logic of a network interface board. The host reaches it through a 16-bit word port with a 2-bit word select. One status/control word drives the network controller's reset, channel-attention, loopback-release (on-air) and secondary-bus-enable lines, and holds two interrupt enables. The same word reports the controller interrupt flag, a parity-error flag and two board straps: the RAM device size and the RAM base nibble.

Board memory parity errors arrive on a valid/ready event channel. The block keeps the first one it accepts: the failing address, the source and the failing byte lane. It drops `perr_ready` until software acknowledges the error. A source that finds `perr_ready` low may hold its event or drop it. A held event is accepted on the first edge at which `perr_ready` is high again.

The interrupt request combines the controller interrupt and the parity error, each under its own enable. Software resets the controller by setting the reset bit, waiting, and clearing it. It signals attention by setting the attention bit and then clearing it.

Top module: `brd_ctl_regs`

## Requirements
- R1: Word 0 (probe word) always reads 0x0000.
- R2: In word 1, bit 15 drives `ctl_reset`, bit 14 `ctl_onair`, bit 13 `ctl_attn` and bit 5 `sec_bus_en`. Each line follows the written value from the edge of the write onward, and each bit reads back as written.
- R3: Word 1 bit 8 shows `ctl_irq_in` as registered on the previous clock edge. Bit 4 shows strap `ram_256k` and bits 3:0 show strap `ram_base`. Host writes to bits 9, 8, 4 and 3:0 have no effect.
- R4: When `perr_valid` and `perr_ready` are both high at an edge, the error is latched. Word 2 bit 7 holds the source, bit 6 the byte lane and bits 3:0 address bits 19:16. Word 3 holds address bits 15:0. Word 1 bit 9 sets and `perr_ready` falls.
- R5: While the parity flag is set, later events are not taken and the latched fields do not change.
- R6: A write to word 2 with bit 8 set clears the flag and all latched fields, and raises `perr_ready`. A write to word 2 with bit 8 clear has no effect. Bit 8 reads as 0.
- R7: `irq_out` = (word 1 bit 12 AND controller interrupt flag) OR (word 1 bit 11 AND parity flag).
- R8: While `rst_n` is low, all control bits, enables, flags and latched fields are zero.
- R9: Host writes to words 0 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_wr | input | 1 | Host write strobe, one word per cycle |
| reg_sel | input | 2 | Word select: 0 probe, 1 status, 2 parity control, 3 parity low address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for the selected word (combinational) |
| ram_base | input | 4 | Strap: board RAM address bits 17-20 |
| ram_256k | input | 1 | Strap: 256 Kbit RAM devices fitted |
| ctl_irq_in | input | 1 | Interrupt from the network controller |
| perr_valid | input | 1 | Parity error event valid |
| perr_ready | output | 1 | High when no error is latched |
| perr_addr | input | 20 | Failing word address |
| perr_src | input | 1 | Error source attribute |
| perr_byte | input | 1 | Failing byte lane |
| ctl_reset | output | 1 | Controller reset, level |
| ctl_onair | output | 1 | Loopback release |
| ctl_attn | output | 1 | Channel attention |
| sec_bus_en | output | 1 | Secondary memory bus enable |
| irq_out | output | 1 | Interrupt request to host |

## Verification
The assertions take three things for granted. The host issues at most one write per cycle, the write is qualified only by `reg_wr`, and `reg_sel` is always a defined 2-bit value. Parity events may arrive at any time, including while an error is latched, and the checks rely on `perr_ready` to decide whether an event was taken. The stimulus drives all inputs on the falling edge and holds them for one full cycle. It also presents a second event while an error is held, so that the capture-and-hold rule is exercised within those assumptions.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_PROBE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STAT  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_PCTL  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_PADR  = 2'd3;

  // status word bit positions
  localparam int B_RST   = 15;
  localparam int B_ONAIR = 14;
  localparam int B_ATTN  = 13;
  localparam int B_IEN   = 12;
  localparam int B_PIEN  = 11;
  localparam int B_PFLAG = 9;
  localparam int B_IFLAG = 8;
  localparam int B_SEC   = 5;
  localparam int B_256K  = 4;

  // parity control word bit positions
  localparam int B_ACK   = 8;
  localparam int B_SRC   = 7;
  localparam int B_BYTE  = 6;

  typedef struct packed {
    logic rst;
    logic onair;
    logic attn;
    logic ien;
    logic pien;
    logic sec;
  } ctl_bits_t;
endpackage

// File: rtl/brd_ctl_word.sv
module brd_ctl_word
  import brd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_in,
  output ctl_bits_t         ctl_q,
  output logic              iflag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      iflag_q <= 1'b0;
    end else begin
      iflag_q <= irq_in;
      if (wr_en) begin
        ctl_q.rst   <= wdata[B_RST];
        ctl_q.onair <= wdata[B_ONAIR];
        ctl_q.attn  <= wdata[B_ATTN];
        ctl_q.ien   <= wdata[B_IEN];
        ctl_q.pien  <= wdata[B_PIEN];
        ctl_q.sec   <= wdata[B_SEC];
      end
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[10:6], wdata[4:0]};
endmodule

// File: rtl/brd_perr_capture.sv
module brd_perr_capture #(
  parameter int HI_W = 4,
  parameter int LO_W = 16,
  localparam int ADDR_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_src,
  input  logic              ev_byte,
  input  logic              ack,
  output logic              flag_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              src_q,
  output logic              byte_q
);
  logic take;
  assign ev_ready = ~flag_q;
  assign take     = ev_valid & ev_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      src_q  <= 1'b0;
      byte_q <= 1'b0;
    end else if (take) begin
      flag_q <= 1'b1;
      addr_q <= ev_addr;
      src_q  <= ev_src;
      byte_q <= ev_byte;
    end else if (ack && flag_q) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      src_q  <= 1'b0;
      byte_q <= 1'b0;
    end
  end
endmodule

// File: rtl/brd_irq_merge.sv
module brd_irq_merge #(
  parameter bit IRQ_REG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ien,
  input  logic iflag,
  input  logic pien,
  input  logic pflag,
  output logic irq
);
  logic raw;
  assign raw = (ien & iflag) | (pien & pflag);

  generate
    if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= raw;
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = raw;
    end
  endgenerate
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
  import brd_pkg::*;
#(
  parameter int ADDR_HI_W = 4,
  parameter int ADDR_LO_W = 16,
  parameter bit IRQ_REG   = 1'b0,
  localparam int ADDR_W   = ADDR_HI_W + ADDR_LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [3:0]        ram_base,
  input  logic              ram_256k,
  input  logic              ctl_irq_in,
  input  logic              perr_valid,
  output logic              perr_ready,
  input  logic [ADDR_W-1:0] perr_addr,
  input  logic              perr_src,
  input  logic              perr_byte,
  output logic              ctl_reset,
  output logic              ctl_onair,
  output logic              ctl_attn,
  output logic              sec_bus_en,
  output logic              irq_out
);
  ctl_bits_t         ctl_q;
  logic              iflag_q;
  logic              pflag_q;
  logic [ADDR_W-1:0] paddr_q;
  logic              psrc_q;
  logic              pbyte_q;
  logic              stat_wr;
  logic              ack_wr;

  assign stat_wr = reg_wr && (reg_sel == SEL_STAT);
  assign ack_wr  = reg_wr && (reg_sel == SEL_PCTL) && reg_wdata[B_ACK];

  brd_ctl_word u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (stat_wr),
    .wdata   (reg_wdata),
    .irq_in  (ctl_irq_in),
    .ctl_q   (ctl_q),
    .iflag_q (iflag_q)
  );

  brd_perr_capture #(.HI_W(ADDR_HI_W), .LO_W(ADDR_LO_W)) u_perr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (perr_valid),
    .ev_ready (perr_ready),
    .ev_addr  (perr_addr),
    .ev_src   (perr_src),
    .ev_byte  (perr_byte),
    .ack      (ack_wr),
    .flag_q   (pflag_q),
    .addr_q   (paddr_q),
    .src_q    (psrc_q),
    .byte_q   (pbyte_q)
  );

  brd_irq_merge #(.IRQ_REG(IRQ_REG)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ien   (ctl_q.ien),
    .iflag (iflag_q),
    .pien  (ctl_q.pien),
    .pflag (pflag_q),
    .irq   (irq_out)
  );

  assign ctl_reset  = ctl_q.rst;
  assign ctl_onair  = ctl_q.onair;
  assign ctl_attn   = ctl_q.attn;
  assign sec_bus_en = ctl_q.sec;

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] pctl_word;
  logic [DATA_W-1:0] padr_word;

  always_comb begin
    stat_word          = '0;
    stat_word[B_RST]   = ctl_q.rst;
    stat_word[B_ONAIR] = ctl_q.onair;
    stat_word[B_ATTN]  = ctl_q.attn;
    stat_word[B_IEN]   = ctl_q.ien;
    stat_word[B_PIEN]  = ctl_q.pien;
    stat_word[B_PFLAG] = pflag_q;
    stat_word[B_IFLAG] = iflag_q;
    stat_word[B_SEC]   = ctl_q.sec;
    stat_word[B_256K]  = ram_256k;
    stat_word[3:0]     = ram_base;

    pctl_word                = '0;
    pctl_word[B_SRC]         = psrc_q;
    pctl_word[B_BYTE]        = pbyte_q;
    pctl_word[ADDR_HI_W-1:0] = paddr_q[ADDR_W-1:ADDR_LO_W];

    padr_word = '0;
    padr_word[ADDR_LO_W-1:0] = paddr_q[ADDR_LO_W-1:0];

    unique case (reg_sel)
      SEL_STAT: reg_rdata = stat_word;
      SEL_PCTL: reg_rdata = pctl_word;
      SEL_PADR: reg_rdata = padr_word;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/brd_ctl_chk.sv
module brd_ctl_chk
  import brd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              perr_valid,
  input logic              perr_ready,
  input logic [ADDR_W-1:0] paddr_q,
  input logic              ctl_reset,
  input logic              ien,
  input logic              pien,
  input logic              irq_out
);
  AST_PROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_PROBE) |-> (reg_rdata == '0)); // R1

  AST_RST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_STAT) |=> (ctl_reset == $past(reg_wdata[B_RST]))); // R2

  AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_valid && perr_ready) |=> !perr_ready); // R4

  AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_ready && !(reg_wr && reg_sel == SEL_PCTL && reg_wdata[B_ACK]))
      |=> (!perr_ready && $stable(paddr_q))); // R5

  AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_ready && reg_wr && reg_sel == SEL_PCTL && reg_wdata[B_ACK])
      |=> (perr_ready && paddr_q == '0)); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !pien) |-> !irq_out); // R7
endmodule

bind brd_ctl_regs brd_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .perr_valid (perr_valid),
  .perr_ready (perr_ready),
  .paddr_q    (paddr_q),
  .ctl_reset  (ctl_reset),
  .ien        (ctl_q.ien),
  .pien       (ctl_q.pien),
  .irq_out    (irq_out)
);

// File: tb/sim_brd_ctl_regs.sv
`timescale 1ns/1ps
module sim_brd_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  ram_base = 4'h9;
  logic        ram_256k = 1'b1;
  logic        ctl_irq_in = 1'b0;
  logic        perr_valid = 1'b0;
  logic        perr_ready;
  logic [19:0] perr_addr = '0;
  logic        perr_src = 1'b0;
  logic        perr_byte = 1'b0;
  logic        ctl_reset, ctl_onair, ctl_attn, sec_bus_en, irq_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  brd_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_base(ram_base),
    .ram_256k(ram_256k), .ctl_irq_in(ctl_irq_in), .perr_valid(perr_valid),
    .perr_ready(perr_ready), .perr_addr(perr_addr), .perr_src(perr_src),
    .perr_byte(perr_byte), .ctl_reset(ctl_reset), .ctl_onair(ctl_onair),
    .ctl_attn(ctl_attn), .sec_bus_en(sec_bus_en), .irq_out(irq_out)
  );

  // {write value, expected status read} with straps 0x19, no flags set
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {16'hFFFF, 16'hF839},
    {16'h0000, 16'h0019},
    {16'h4000, 16'h4019},
    {16'h0320, 16'h0039},
    {16'h2000, 16'h2019},
    {16'h100F, 16'h1019}
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    reg_sel = s;
    #2;
    d = reg_rdata;
  endtask

  task automatic perr(input logic [19:0] a, input logic s, input logic b);
    @(negedge clk);
    perr_valid = 1'b1; perr_addr = a; perr_src = s; perr_byte = b;
    @(negedge clk);
    perr_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R8 reset state
    rd(2'd1, v); chk("R8 status", v, 20'h0019);
    chk("R8 outputs", {ctl_reset, ctl_onair, ctl_attn, sec_bus_en, irq_out}, 20'h0);
    chk("R8 ready", perr_ready, 20'h1);
    rd(2'd2, v); chk("R8 pctl", v, 20'h0);
    rd(2'd3, v); chk("R8 padr", v, 20'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3 vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, VEC[i][31:16]);
      rd(2'd1, v);
      chk("R3 status readback", v, VEC[i][15:0]);
      chk("R2 control lines", {ctl_reset, ctl_onair, ctl_attn, sec_bus_en},
          {16'h0, VEC[i][31], VEC[i][30], VEC[i][29], VEC[i][21]});
    end
    wr(2'd1, 16'h0000);

    // R1 / R9 probe word
    rd(2'd0, v); chk("R1 probe zero", v, 20'h0);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R9 probe write ignored", v, 20'h0);
    rd(2'd1, v); chk("R9 status untouched", v, 20'h0019);

    // R3 / R7 controller interrupt
    @(negedge clk); ctl_irq_in = 1'b1;
    @(negedge clk);
    rd(2'd1, v); chk("R3 iflag", v, 20'h0119);
    chk("R7 irq gated", irq_out, 20'h0);
    wr(2'd1, 16'h1000);
    chk("R7 irq ctl", irq_out, 20'h1);
    @(negedge clk); ctl_irq_in = 1'b0;
    @(negedge clk);
    chk("R7 irq drops", irq_out, 20'h0);
    wr(2'd1, 16'h0000);

    // R4 capture
    perr(20'h5ABCD, 1'b1, 1'b0);
    rd(2'd2, v); chk("R4 pctl", v, 20'h0085);
    rd(2'd3, v); chk("R4 padr", v, 20'hABCD);
    rd(2'd1, v); chk("R4 pflag", v, 20'h0219);
    chk("R4 ready low", perr_ready, 20'h0);
    chk("R7 pirq gated", irq_out, 20'h0);
    wr(2'd1, 16'h0800);
    chk("R7 pirq", irq_out, 20'h1);

    // R5 hold first
    perr(20'h31234, 1'b0, 1'b1);
    rd(2'd2, v); chk("R5 pctl held", v, 20'h0085);
    rd(2'd3, v); chk("R5 padr held", v, 20'hABCD);

    // R9 low address write ignored
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R9 padr write ignored", v, 20'hABCD);

    // R6 write without ack
    wr(2'd2, 16'h00FF);
    rd(2'd2, v); chk("R6 no-ack write", v, 20'h0085);
    chk("R6 still busy", perr_ready, 20'h0);

    // R6 ack
    wr(2'd2, 16'h0100);
    rd(2'd2, v); chk("R6 pctl cleared", v, 20'h0);
    rd(2'd3, v); chk("R6 padr cleared", v, 20'h0);
    rd(2'd1, v); chk("R6 pflag cleared", v, 20'h0819);
    chk("R6 ready back", perr_ready, 20'h1);
    chk("R7 pirq clears", irq_out, 20'h0);

    // R4 byte lane field
    perr(20'hF0001, 1'b0, 1'b1);
    rd(2'd2, v); chk("R4 byte lane", v, 20'h004F);
    rd(2'd3, v); chk("R4 padr 2", v, 20'h0001);

    // R8 reset mid-run
    wr(2'd1, 16'hF820);
    @(negedge clk); rst_n = 1'b0;
    #2;
    rd(2'd1, v); chk("R8 status after reset", v, 20'h0019);
    rd(2'd2, v); chk("R8 pctl after reset", v, 20'h0);
    chk("R8 lines after reset", {ctl_reset, ctl_onair, ctl_attn, sec_bus_en, irq_out}, 20'h0);
    @(negedge clk); rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule